// File: doc/BRIEF.md
# Two-Frame-Latency SPI Converter Stand-In

This block is a synthesizable SPI slave that behaves like a multi-channel sampling converter whose answers arrive two frames late. It is meant to sit opposite a sequencer or SPI master on a test die or in a prototype, so that the master's command scheduling, pipelining and tag checking can be exercised against digital sample values instead of analog inputs. The SPI pins are oversampled by the system clock: chip select, serial clock and data-in pass through a short synchronizer, and all edge detection happens in the `clk` domain.

Each 16-clock frame carries a command word from the master. When the command's write flag is set, the channel field replaces the stored channel; otherwise the stored channel stays in force. At the close of every valid frame the selected channel's value is taken from the parallel `sample_bus`. The frame that follows is the conversion slot. The reply goes out in the frame after that, with the channel number as a 4-bit tag above the left-aligned data. The mode and range bits of the command have no digital effect here, so they are not stored.

Top module: `lagged_adc_slave`

## Requirements
- R1: A frame is accepted only when exactly 16 rising edges of `sclk` occur while `cs_n` is low, followed by `cs_n` rising. A frame with fewer or more clocks changes neither the stored channel nor the reply pipeline.
- R2: In an accepted frame with command bit 11 set, command bits 10:7 become the stored channel. With bit 11 clear, the stored channel is kept and the sample is taken from it.
- R3: The sample taken at the end of accepted frame N is shifted out during frame N+2, the second accepted frame after it.
- R4: The reply word holds the channel tag in bits 15:12 and the RES-bit sample in bits 11 down to 12-RES. Bits below the sample are zero.
- R5: A tagged channel number that is at or above NCH returns zero data while still carrying its tag.
- R6: `miso` is low while `cs_n` is high. During a frame, bit 15 is present after `cs_n` falls, and each following bit is presented after a falling `sclk` edge, most significant first.
- R7: After reset the stored channel is 0 and the first two frames return an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the master (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Command bits from the master, MSB first |
| sample_bus | input | NCH*RES | Per-channel sample values; channel c occupies bits c*RES +: RES |
| miso | output | 1 | Reply bits to the master, MSB first |

## Verification
A stored channel that is wrong, or a pipeline stage that moves on a discarded frame, shows at the ports as a wrong tag nibble two accepted frames later. The tag is the first four bits out, so such a fault is visible within the first few `sclk` periods of that reply. A mis-aligned or mis-padded data field shows in the same reply word as misplaced or non-zero low bits. Clocks and commands are swept over every channel code, including codes above the channel count, and the bench compares each reply bit against a three-register arithmetic model of the pipeline.

// File: rtl/lag_adc_pkg.sv
// Shared frame geometry for the lagged converter stand-in.
package lag_adc_pkg;
    localparam int FRAME_LEN = 16;                  // clocks per accepted frame
    localparam int TAG_W     = 4;                   // channel tag width
    localparam int DATA_SPAN = FRAME_LEN - TAG_W;   // bits below the tag
    localparam int CMD_KEEP  = DATA_SPAN;           // command bits retained
    typedef logic [FRAME_LEN-1:0] word_t;
    typedef logic [TAG_W-1:0]     chan_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes the three SPI input pins into clk and derives edge strobes.
// Assumes sclk and cs_n stay in each level for more than SYNC_STAGES+1 clk cycles.
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_on,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);
    logic [SYNC_STAGES-1:0] sclk_p, csn_p, mosi_p;
    logic sclk_d, csn_d;

    // Shift pins through the synchronizer chain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            csn_p  <= '1;
            mosi_p <= '0;
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
            csn_p  <= {csn_p[SYNC_STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
            sclk_d <= sclk_p[SYNC_STAGES-1];
            csn_d  <= csn_p[SYNC_STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[SYNC_STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[SYNC_STAGES-1] & sclk_d;
    assign cs_on     = ~csn_p[SYNC_STAGES-1];
    assign cs_start  = ~csn_p[SYNC_STAGES-1] & csn_d;
    assign cs_end    = csn_p[SYNC_STAGES-1] & ~csn_d;
    assign mosi_s    = mosi_p[SYNC_STAGES-1];
endmodule

// File: rtl/cmd_frame_rx.sv
// Collects command bits on rising sclk and flags a frame of exactly FRAME_LEN clocks.
// Assumes cs_start and sclk_rise never coincide.
module cmd_frame_rx
    import lag_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       cs_on,
    input  logic       cs_start,
    input  logic       cs_end,
    input  logic       mosi_s,
    output logic       frame_ok,
    output logic [4:0] ctl_bits,
    output logic [$clog2(FRAME_LEN+2)-1:0] bit_cnt
);
    localparam int CNT_W = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);

    logic [CMD_KEEP-1:0] shreg;

    // Count clocks (saturating past full), shift data, flag a clean frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= cs_end && (bit_cnt == CNT_FULL);
            if (cs_start) begin
                bit_cnt <= '0;
            end else if (cs_on && sclk_rise) begin
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
                shreg <= {shreg[CMD_KEEP-2:0], mosi_s};
            end
        end
    end

    // Write flag (bit 11) and channel field (bits 10:7).
    assign ctl_bits = shreg[11:7];
endmodule

// File: rtl/reply_pipe.sv
// Samples the selected channel at frame close, holds it for one frame,
// then serializes it with its tag. Assumes NCH in 1..16 and RES in 1..12.
module reply_pipe
    import lag_adc_pkg::*;
#(
    parameter int NCH = 16,
    parameter int RES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ok,
    input  logic [4:0]       ctl_bits,
    input  logic [NCH*RES-1:0] sample_bus,
    input  logic             cs_on,
    input  logic             cs_start,
    input  logic             sclk_fall,
    output logic             miso,
    output word_t            stage_a,
    output word_t            tx_word
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [RES-1:0] ch_val [NCH];
    chan_t          chan, next_chan;
    logic [RES-1:0] picked;
    logic           in_range;
    word_t          new_word, tx_sh;

    for (genvar g = 0; g < NCH; g++) begin : g_slice
        assign ch_val[g] = sample_bus[g*RES +: RES];
    end

    // Choose the channel for this frame and build its tagged word.
    always_comb begin
        next_chan = ctl_bits[4] ? ctl_bits[3:0] : chan;
        in_range  = ({1'b0, next_chan} < 5'(NCH));
        picked    = in_range ? ch_val[next_chan[IDX_W-1:0]] : '0;
        new_word  = '0;
        new_word[FRAME_LEN-1 -: TAG_W] = next_chan;
        new_word[DATA_SPAN-1 -: RES]   = picked;
    end

    // Advance the two-frame pipeline and shift the reply out on falling sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan    <= '0;
            stage_a <= '0;
            tx_word <= '0;
            tx_sh   <= '0;
        end else begin
            if (frame_ok) begin
                chan    <= next_chan;
                stage_a <= new_word;
                tx_word <= stage_a;
            end
            if (cs_start) tx_sh <= tx_word;
            else if (cs_on && sclk_fall) tx_sh <= {tx_sh[FRAME_LEN-2:0], 1'b0};
        end
    end

    assign miso = cs_on & tx_sh[FRAME_LEN-1];
endmodule

// File: rtl/lagged_adc_slave.sv
// Top: SPI slave standing in for a multi-channel converter whose reply
// lags its command by two frames. All logic runs on clk; SPI pins are oversampled.
module lagged_adc_slave
    import lag_adc_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int RES         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [NCH*RES-1:0] sample_bus,
    output logic               miso
);
    logic sclk_rise, sclk_fall, cs_on, cs_start, cs_end, mosi_s;
    logic frame_ok;
    logic [4:0] ctl_bits;
    logic [$clog2(FRAME_LEN+2)-1:0] bit_cnt;
    word_t stage_a, tx_word;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_on(cs_on),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
    );

    cmd_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_on(cs_on),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s),
        .frame_ok(frame_ok), .ctl_bits(ctl_bits), .bit_cnt(bit_cnt)
    );

    reply_pipe #(.NCH(NCH), .RES(RES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .ctl_bits(ctl_bits),
        .sample_bus(sample_bus), .cs_on(cs_on), .cs_start(cs_start),
        .sclk_fall(sclk_fall), .miso(miso), .stage_a(stage_a), .tx_word(tx_word)
    );
endmodule

// File: rtl/lagged_adc_chk.sv
// Property checker for lagged_adc_slave, attached through bind below.
module lagged_adc_chk
    import lag_adc_pkg::*;
#(
    parameter int NCH = 16,
    parameter int RES = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input logic       cs_on,
    input logic       cs_start,
    input logic       sclk_fall,
    input logic       frame_ok,
    input logic [$clog2(FRAME_LEN+2)-1:0] bit_cnt,
    input word_t      stage_a,
    input word_t      tx_word
);
    // R6: pin held high for several cycles means the output is low.
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // R6: inside a frame the output only moves on a falling clock or frame start.
    a_r6_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_on && !sclk_fall && !cs_start) |=> (!cs_on || $stable(miso)));

    // R1: an accepted frame saw exactly sixteen clocks.
    a_r1_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> ($past(bit_cnt) == 5'(FRAME_LEN)));

    // R3: pipeline stages move only on an accepted frame.
    a_r3_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> ($stable(tx_word) && $stable(stage_a)));

    // R5: tags beyond the channel count carry no data.
    a_r5_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, stage_a[15:12]} >= 5'(NCH)) |-> (stage_a[11:0] == '0));

    if (RES < DATA_SPAN) begin : g_pad
        localparam word_t PAD_MASK = word_t'((1 << (DATA_SPAN - RES)) - 1);
        // R4: bits below the sample field stay zero.
        a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ((stage_a & PAD_MASK) == '0) && ((tx_word & PAD_MASK) == '0));
    end
endmodule

bind lagged_adc_slave lagged_adc_chk #(.NCH(NCH), .RES(RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .cs_on(cs_on),
    .cs_start(cs_start), .sclk_fall(sclk_fall), .frame_ok(frame_ok),
    .bit_cnt(bit_cnt), .stage_a(stage_a), .tx_word(tx_word)
);

// File: tb/tb_lagged_adc_slave.sv
module tb_lagged_adc_slave;
    localparam int NCH  = 8;
    localparam int RES  = 10;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, mosi;
    logic [NCH*RES-1:0] sample_bus;
    logic miso;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    logic [3:0]  m_chan;
    logic [15:0] m_a, m_tx;

    always #5 clk = ~clk;

    lagged_adc_slave #(.NCH(NCH), .RES(RES)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sample_bus(sample_bus), .miso(miso)
    );

    function automatic logic [RES-1:0] val(input int ch, input int rnd);
        return RES'((ch * 97 + rnd * 29 + 3) % (1 << RES));
    endfunction

    function automatic logic [15:0] mk_word(input logic [3:0] ch, input int rnd);
        logic [15:0] w = '0;
        w[15:12] = ch;
        if (int'(ch) < NCH) w[11 -: RES] = val(int'(ch), rnd);
        return w;
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_samples();
        k++;
        for (int c = 0; c < NCH; c++) sample_bus[c*RES +: RES] = val(c, k);
    endtask

    task automatic do_frame(input logic [15:0] cmd, input int nclk, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? cmd[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) got[15-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        check(miso == 1'b0, "R6 idle", {15'd0, miso}, 16'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic full(input logic [15:0] cmd, input string req);
        logic [15:0] got;
        logic [3:0]  nc;
        set_samples();
        do_frame(cmd, 16, got);
        check(got == m_tx, req, got, m_tx);
        nc     = cmd[11] ? cmd[10:7] : m_chan;
        m_tx   = m_a;
        m_a    = mk_word(nc, k);
        m_chan = nc;
    endtask

    task automatic odd_frame(input logic [15:0] cmd, input int nclk);
        logic [15:0] got, mask;
        mask = (nclk >= 16) ? 16'hFFFF : ~(16'hFFFF >> nclk);
        set_samples();
        do_frame(cmd, nclk, got);
        check((got & mask) == (m_tx & mask), "R1 partial", got & mask, m_tx & mask);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        m_chan = '0; m_a = '0; m_tx = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; sample_bus = '0;
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check(miso == 1'b0, "R7 reset", {15'd0, miso}, 16'd0);
        // R7: first two replies are zero
        full(16'h0800 | (16'd5 << 7), "R7");
        full(16'h0800 | (16'd6 << 7), "R7");
        // R3 R4 R5: every channel code, mode/range bits varied
        for (int ch = 0; ch < 16; ch++)
            full(16'h0800 | 16'(ch << 7) | ((ch % 2) ? 16'h1040 : 16'h0000),
                 (ch < NCH) ? "R4" : "R5");
        for (int ch = 15; ch >= 0; ch--)
            full(16'h0800 | 16'(ch << 7) | 16'h003F, "R3");
        // R2: write flag clear keeps channel
        full(16'h0380, "R2");
        full(16'h0000, "R2");
        full(16'h0800 | (16'd2 << 7), "R2");
        full(16'h0780, "R2");
        full(16'h0000, "R2");
        full(16'h0000, "R2");
        // R1: short and long frames are discarded
        odd_frame(16'h0800 | (16'd1 << 7), 9);
        full(16'h0000, "R1");
        full(16'h0000, "R1");
        odd_frame(16'h0800 | (16'd4 << 7), 17);
        full(16'h0000, "R1");
        full(16'h0000, "R1");
        full(16'h0800 | (16'd3 << 7), "R1");
        // R7: mid-run reset clears pipeline and channel
        do_reset();
        full(16'h0000, "R7");
        full(16'h0000, "R7");
        full(16'h0000, "R7");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule